// File: doc/BRIEF.md
# Identification Frame Receiver with Parity Validation

This block sits on the reading side of a contactless identification link. It accepts a stream of already decoded bits, each qualified by a one-cycle strobe, and turns that stream into identifier words. It hunts for the synchronisation run of ones that opens every frame. It then gathers the body of the frame, which is a grid of data rows each closed by a row parity bit, a trailing row of column parity bits and a final stop bit. It checks every part of that structure as the bits arrive.

A frame that passes every check is offered to a confirmation stage. An identifier is only reported once the same word has arrived in a run of consecutive good frames, which keeps isolated noise hits out. A frame that fails a check raises a one-cycle error pulse and sends the receiver straight back to hunting. Tags repeat their frame endlessly, so the next header may follow a stop bit with no gap at all.

Top module: `idrx_frame_rx`

## Requirements
- R1: While reset is held and in the first cycle after it, `id_vld` and `frame_err` are low and `id_out` and `cust_id` are zero.
- R2: Only cycles with `bit_vld` high advance the receiver. Idle cycles between strobes change nothing. Lock is declared on the HDR_LEN-th consecutive strobed 1, and any strobed 0 restarts the count.
- R3: After lock, the body is taken in this order: ROWS rows of COLS data bits each followed by one row parity bit, then COLS column parity bits, then the stop bit. The k-th data bit received (k counted from 0) appears on `id_out[ROWS*COLS-1-k]`, and `id_out` changes only together with an `id_vld` pulse.
- R4: Each row's data bits plus its parity bit must hold an even number of ones. On a violation, `frame_err` pulses in the cycle after that parity bit is strobed, no identifier results, and header search resumes with the next strobed bit.
- R5: For each column c, the ROWS data bits of column c plus the c-th column parity bit must hold an even number of ones. A violation makes `frame_err` pulse in the cycle after the stop bit.
- R6: The stop bit must be 0. A 1 makes `frame_err` pulse in the cycle after it.
- R7: `cust_id` presents the first CUST_W data bits of the reported frame, with the first received bit as its MSB.
- R8: With CONFIRM >= 2, `id_vld` pulses for one cycle, in the cycle after the stop bit, when a good frame completes a run of CONFIRM consecutive good frames carrying the same word. Further repeats of that word do not pulse again. A different word starts a new run of one. A failed frame clears the run.
- R9: A header whose first bit is strobed directly after a stop bit is recognised without any idle bit in between.
- R10: A candidate header broken by a 0 yields neither an error nor an identifier. The frame body that follows it cannot produce a lock.
- R11: `id_vld` and `frame_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_vld | input | 1 | Strobe qualifying `bit_val` for one cycle |
| bit_val | input | 1 | Decoded serial bit |
| id_vld | output | 1 | One-cycle pulse: a confirmed identifier is on `id_out` |
| id_out | output | ROWS*COLS | Confirmed identifier, first received bit at the MSB |
| cust_id | output | CUST_W | Leading CUST_W bits of the confirmed identifier |
| frame_err | output | 1 | One-cycle pulse: a row, column or stop check failed |

## Verification
The bench builds the block with its default parameters: a nine-bit header, a ten-by-four grid, an eight-bit customer field and a confirmation depth of two. At that size a frame body is only 55 bits long. This lets the bench flip every body position one at a time, which reaches each row, column and stop failure path, and it walks a single set bit across all forty identifier positions. The same configuration also covers back-to-back frames, idle gaps between strobes, broken headers and runs of two frames that disagree.

// File: rtl/idrx_pkg.sv
package idrx_pkg;

   // Receiver phase: hunting for the header, or inside one part of the body.
   typedef enum logic [1:0] {
      PH_HUNT = 2'd0,
      PH_ROWS = 2'd1,
      PH_COLS = 2'd2,
      PH_STOP = 2'd3
   } rx_phase_e;

endpackage

// File: rtl/idrx_hdr_sync.sv
module idrx_hdr_sync #(
   parameter int HDR_LEN = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic bit_vld,
   input  logic bit_val,
   output logic lock
);
   localparam int H_W = (HDR_LEN > 1) ? $clog2(HDR_LEN) : 1;

   logic [H_W-1:0] ones_q;
   logic           last_one;

   assign last_one = (ones_q == H_W'(HDR_LEN - 1));
   assign lock     = arm && bit_vld && bit_val && last_one;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_q <= '0;
      end else if (!arm) begin
         ones_q <= '0;
      end else if (bit_vld) begin
         if (!bit_val || last_one) ones_q <= '0;
         else                      ones_q <= ones_q + 1'b1;
      end
   end
endmodule

// File: rtl/idrx_body_check.sv
module idrx_body_check
   import idrx_pkg::*;
#(
   parameter int ROWS = 10,
   parameter int COLS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 bit_vld,
   input  logic                 bit_val,
   output logic                 busy,
   output logic                 done_ok,
   output logic                 done_bad,
   output logic [ROWS*COLS-1:0] word
);
   localparam int ID_W  = ROWS * COLS;
   localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
   localparam int COL_W = $clog2(COLS + 1);

   rx_phase_e          phase_q;
   logic [ROW_W-1:0]   row_q;
   logic [COL_W-1:0]   col_q;
   logic               row_acc_q;
   logic [COLS-1:0]    col_acc_q;
   logic [ID_W-1:0]    sr_q;

   logic at_row_par, row_fail, stop_seen;

   assign at_row_par = (phase_q == PH_ROWS) && (col_q == COL_W'(COLS));
   assign row_fail   = bit_vld && at_row_par && (row_acc_q ^ bit_val);
   assign stop_seen  = bit_vld && (phase_q == PH_STOP);
   assign done_ok    = stop_seen && !bit_val && (col_acc_q == '0);
   assign done_bad   = row_fail || (stop_seen && !done_ok);
   assign busy       = (phase_q != PH_HUNT);
   assign word       = sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_HUNT;
         row_q     <= '0;
         col_q     <= '0;
         row_acc_q <= 1'b0;
         col_acc_q <= '0;
         sr_q      <= '0;
      end else if (start) begin
         phase_q   <= PH_ROWS;
         row_q     <= '0;
         col_q     <= '0;
         row_acc_q <= 1'b0;
         col_acc_q <= '0;
      end else if (bit_vld) begin
         unique case (phase_q)
            PH_ROWS: begin
               if (!at_row_par) begin
                  sr_q      <= {sr_q[ID_W-2:0], bit_val};
                  row_acc_q <= row_acc_q ^ bit_val;
                  for (int c = 0; c < COLS; c++) begin
                     if (col_q == COL_W'(c)) col_acc_q[c] <= col_acc_q[c] ^ bit_val;
                  end
                  col_q <= col_q + 1'b1;
               end else if (row_fail) begin
                  phase_q <= PH_HUNT;
               end else begin
                  col_q     <= '0;
                  row_acc_q <= 1'b0;
                  if (row_q == ROW_W'(ROWS - 1)) phase_q <= PH_COLS;
                  else                           row_q   <= row_q + 1'b1;
               end
            end
            PH_COLS: begin
               for (int c = 0; c < COLS; c++) begin
                  if (col_q == COL_W'(c)) col_acc_q[c] <= col_acc_q[c] ^ bit_val;
               end
               col_q <= col_q + 1'b1;
               if (col_q == COL_W'(COLS - 1)) phase_q <= PH_STOP;
            end
            PH_STOP: phase_q <= PH_HUNT;
            default: phase_q <= PH_HUNT;
         endcase
      end
   end
endmodule

// File: rtl/idrx_confirm.sv
module idrx_confirm #(
   parameter int ID_W    = 40,
   parameter int CONFIRM = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            good,
   input  logic            bad,
   input  logic [ID_W-1:0] word,
   output logic            id_vld,
   output logic [ID_W-1:0] id_q
);
   generate
      if (CONFIRM == 1) begin : g_direct
         // Every good frame is reported at once.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               id_vld <= 1'b0;
               id_q   <= '0;
            end else begin
               id_vld <= good;
               if (good) id_q <= word;
            end
         end
         logic unused_bad;
         assign unused_bad = bad;
      end else begin : g_vote
         localparam int RUN_W = $clog2(CONFIRM + 1);
         logic [RUN_W-1:0] run_q;
         logic [ID_W-1:0]  last_q;
         logic             same, fire;

         assign same = (run_q != '0) && (word == last_q);
         assign fire = good && same && (run_q == RUN_W'(CONFIRM - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q  <= '0;
               last_q <= '0;
               id_vld <= 1'b0;
               id_q   <= '0;
            end else begin
               id_vld <= fire;
               if (fire) id_q <= word;
               if (bad) begin
                  run_q <= '0;
               end else if (good) begin
                  last_q <= word;
                  if (!same)                            run_q <= RUN_W'(1);
                  else if (run_q != RUN_W'(CONFIRM))    run_q <= run_q + 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/idrx_frame_rx.sv
module idrx_frame_rx #(
   parameter int HDR_LEN = 9,
   parameter int ROWS    = 10,
   parameter int COLS    = 4,
   parameter int CUST_W  = 8,
   parameter int CONFIRM = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bit_vld,
   input  logic                   bit_val,
   output logic                   id_vld,
   output logic [ROWS*COLS-1:0]   id_out,
   output logic [CUST_W-1:0]      cust_id,
   output logic                   frame_err
);
   localparam int ID_W = ROWS * COLS;

   generate
      if (ROWS < 2) begin : g_bad_rows
         $error("idrx_frame_rx: ROWS must be at least 2");
      end
      if (COLS < 1) begin : g_bad_cols
         $error("idrx_frame_rx: COLS must be at least 1");
      end
      if (HDR_LEN <= 2 * COLS) begin : g_bad_hdr
         $error("idrx_frame_rx: HDR_LEN must exceed the longest run of ones a body can hold");
      end
      if (CUST_W < 1 || CUST_W > ID_W) begin : g_bad_cust
         $error("idrx_frame_rx: CUST_W out of range");
      end
      if (CONFIRM < 1) begin : g_bad_conf
         $error("idrx_frame_rx: CONFIRM must be at least 1");
      end
   endgenerate

   logic            busy, lock, ok, bad;
   logic [ID_W-1:0] word;

   idrx_hdr_sync #(.HDR_LEN(HDR_LEN)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (!busy),
      .bit_vld (bit_vld),
      .bit_val (bit_val),
      .lock    (lock)
   );

   idrx_body_check #(.ROWS(ROWS), .COLS(COLS)) u_body (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (lock),
      .bit_vld  (bit_vld),
      .bit_val  (bit_val),
      .busy     (busy),
      .done_ok  (ok),
      .done_bad (bad),
      .word     (word)
   );

   idrx_confirm #(.ID_W(ID_W), .CONFIRM(CONFIRM)) u_conf (
      .clk    (clk),
      .rst_n  (rst_n),
      .good   (ok),
      .bad    (bad),
      .word   (word),
      .id_vld (id_vld),
      .id_q   (id_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) frame_err <= 1'b0;
      else        frame_err <= bad;
   end

   assign cust_id = id_out[ID_W-1 -: CUST_W];
endmodule

// File: rtl/idrx_frame_rx_chk.sv
module idrx_frame_rx_chk #(
   parameter int ID_W   = 40,
   parameter int CUST_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bit_vld,
   input logic              bit_val,
   input logic              id_vld,
   input logic [ID_W-1:0]   id_out,
   input logic [CUST_W-1:0] cust_id,
   input logic              frame_err
);
   // R11
   excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(id_vld && frame_err));

   // R8
   vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      id_vld |=> !id_vld);

   // R4
   err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> !frame_err);

   // R2
   strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (id_vld || frame_err) |-> $past(bit_vld));

   // R6
   stop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      id_vld |-> !$past(bit_val));

   // R3
   id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(id_out) |-> id_vld);

   // R7
   cust_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cust_id) |-> id_vld);
endmodule

bind idrx_frame_rx idrx_frame_rx_chk #(.ID_W(ROWS*COLS), .CUST_W(CUST_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bit_vld   (bit_vld),
   .bit_val   (bit_val),
   .id_vld    (id_vld),
   .id_out    (id_out),
   .cust_id   (cust_id),
   .frame_err (frame_err)
);

// File: tb/idrx_frame_rx_bench.sv
`timescale 1ns/1ps
module idrx_frame_rx_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_vld = 1'b0;
   logic        bit_val = 1'b0;
   logic        id_vld;
   logic [39:0] id_out;
   logic [7:0]  cust_id;
   logic        frame_err;

   int n_chk = 0;
   int n_bad = 0;
   int n_id  = 0;
   int n_err = 0;
   int n_both = 0;
   logic [39:0] seen_id = '0;
   logic [7:0]  seen_cust = '0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   idrx_frame_rx u_idrx_frame_rx (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
      .id_vld(id_vld), .id_out(id_out), .cust_id(cust_id), .frame_err(frame_err)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (id_vld) begin
            n_id++;
            seen_id   = id_out;
            seen_cust = cust_id;
         end
         if (frame_err) n_err++;
         if (id_vld && frame_err) n_both++;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   // Frame image: index 63 is sent first.
   function automatic logic [63:0] mk(input logic [39:0] id);
      logic [63:0] f;
      logic [3:0]  cp;
      logic        rp, b;
      int          p;
      f  = '0;
      cp = '0;
      p  = 63;
      for (int i = 0; i < 9; i++) begin f[p] = 1'b1; p--; end
      for (int r = 0; r < 10; r++) begin
         rp = 1'b0;
         for (int c = 0; c < 4; c++) begin
            b = id[39 - (4*r + c)];
            f[p] = b; p--;
            rp ^= b;
            cp[c] = cp[c] ^ b;
         end
         f[p] = rp; p--;
      end
      for (int c = 0; c < 4; c++) begin f[p] = cp[c]; p--; end
      f[p] = 1'b0;
      return f;
   endfunction

   task automatic send(input logic [63:0] f, input int gap);
      for (int i = 63; i >= 0; i--) begin
         @(negedge clk);
         bit_vld = 1'b1;
         bit_val = f[i];
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            bit_vld = 1'b0;
            bit_val = ~bit_val;
         end
      end
   endtask

   task automatic settle();
      @(negedge clk);
      bit_vld = 1'b0;
      bit_val = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #600000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      report();
   end

   initial begin
      logic [39:0] a, b, c, d, e, w;
      int id0, err0;
      a = 40'hA5_3C_96_0F_E1;
      b = 40'h12_34_56_78_9A;
      c = 40'hFF_00_FF_00_FF;
      d = 40'h0F_0F_0F_0F_0F;
      e = 40'h5A_5A_5A_5A_5A;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!id_vld && !frame_err && id_out == 0 && cust_id == 0, "R1", {id_vld, frame_err, id_out}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!id_vld && !frame_err && id_out == 0, "R1", {id_vld, frame_err, id_out}, 0);

      // R9 R8 R3 R7: two identical back-to-back frames
      send(mk(a), 0); send(mk(a), 0); settle();
      chk(n_id == 1, "R8", n_id, 1);
      chk(seen_id == a, "R3", seen_id, a);
      chk(seen_cust == a[39:32], "R7", seen_cust, a[39:32]);
      chk(n_err == 0, "R9", n_err, 0);

      // R8: a third repeat does not report again
      send(mk(a), 0); settle();
      chk(n_id == 1, "R8", n_id, 1);

      // R4 R5 R6: every single body bit flipped
      for (int j = 0; j < 55; j++) begin
         logic [63:0] f;
         id0 = n_id; err0 = n_err;
         f = mk(b);
         f[54 - j] = ~f[54 - j];
         send(f, 0); send(mk(b), 0); settle();
         if (j < 50)      chk(n_err == err0 + 1, "R4", n_err, err0 + 1);
         else if (j < 54) chk(n_err == err0 + 1, "R5", n_err, err0 + 1);
         else             chk(n_err == err0 + 1, "R6", n_err, err0 + 1);
         chk(n_id == id0, "R8", n_id, id0);
      end
      // R8: run continues from the last good frame of the sweep
      send(mk(b), 1); settle();
      chk(seen_id == b && n_id == 2, "R8", seen_id, b);

      // R8: differing words restart the run
      send(mk(c), 0); send(mk(d), 0); settle();
      chk(n_id == 2, "R8", n_id, 2);
      send(mk(d), 2); settle();
      chk(n_id == 3 && seen_id == d, "R8", seen_id, d);

      // R10: broken header is ignored
      begin
         logic [63:0] f;
         err0 = n_err;
         f = mk(e);
         f[60] = 1'b0;
         send(f, 0); settle();
         chk(n_err == err0 && n_id == 3, "R10", n_err, err0);
         send(mk(e), 0); send(mk(e), 0); settle();
         chk(n_id == 4 && seen_id == e, "R10", seen_id, e);
      end

      // R2 R3 R7: walking one with idle gaps between strobes
      for (int k = 0; k < 40; k++) begin
         w = 40'd1 << k;
         id0 = n_id;
         send(mk(w), k % 3); send(mk(w), (k + 1) % 3); settle();
         chk(n_id == id0 + 1 && seen_id == w, "R2", seen_id, w);
         chk(seen_cust == w[39:32], "R7", seen_cust, w[39:32]);
      end

      // R3: extreme words
      send(mk(40'hFF_FFFF_FFFF), 0); send(mk(40'hFF_FFFF_FFFF), 0); settle();
      chk(seen_id == 40'hFF_FFFF_FFFF, "R3", seen_id, 40'hFF_FFFF_FFFF);
      send(mk(40'h0), 0); send(mk(40'h0), 0); settle();
      chk(seen_id == 40'h0 && n_id == 46, "R3", seen_id, 0);

      // R11
      chk(n_both == 0, "R11", n_both, 0);
      report();
   end
endmodule